// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus with write and read strobes. Software loads a mode word that turns the watchdog on, chooses what happens on expiry, and selects one of twelve timeout periods between half a second and sixteen seconds. After that it must keep writing a restart word that carries a fixed 13-bit key. A write whose key is wrong changes nothing, so a runaway program that writes random values to the control word does not keep the watchdog quiet.

The countdown advances on a half-second tick. A parameterised prescaler divides the system clock to make this tick, and a bench can set a small divide value. When the selected period runs out with no valid restart, the block either drives a system-reset pulse of a fixed number of clock cycles or, if reset is disabled, sets a sticky expiry flag. The expiry flag appears on an output and in the mode word. After expiry the countdown halts until it is re-armed. Software can force a reset by choosing the shortest period with reset enabled and then waiting.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `sys_rst_o` and `irq_o` are 0 and a read of the mode word (offset 0x04) returns 0.
- R2: A write to offset 0x00 restarts the countdown only when bit 0 is 1 and bits [13:1] equal 0x0A57, which is write data 0x000014AF. Any other value written there is ignored and does not move the expiry time.
- R3: Mode word at offset 0x04: bit 0 enable, bit 1 reset-on-expiry, bits [6:3] period selector, bit 2 the read-only expiry flag. Reads of offset 0x00 and of any other offset return 0.
- R4: Period selector codes 0..11 select 0.5, 1, 2, 3, 4, 5, 6, 8, 10, 12, 14 and 16 seconds. Expiry happens exactly (period in half-seconds) × TICK_DIV clock edges after the edge that armed the countdown.
- R5: Selector codes 12 to 15 behave as 16 seconds.
- R6: With reset-on-expiry set, expiry drives `sys_rst_o` high for exactly RST_CYCLES cycles, starting right after the expiry edge, and leaves `irq_o` low.
- R7: With reset-on-expiry clear, expiry sets a sticky flag, shown on `irq_o` and in mode bit 2. Only a keyed restart clears it, and that restart clears it whether or not the block is enabled.
- R8: Writing the mode word with enable 0 stops the countdown and clears its count at once.
- R9: Writing the mode word while enabled stays pending until the next keyed restart. A mode write that changes enable from 0 to 1 arms the countdown at once with the written period.
- R10: After expiry the countdown halts. No further expiry occurs until a keyed restart or an enable change from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is made |
| sys_rst_o | output | 1 | System-reset pulse on expiry |
| irq_o | output | 1 | Sticky expiry flag |

## Verification
The hardest case to reach is a pending mode change that must stay invisible. The stimulus arms a long period, then rewrites the mode word with a shorter period while the countdown is still running. The bench checks that expiry still comes at the old time, and that the short period applies only after the next keyed restart. Rejected keys, and a key with the restart bit clear, are written in the middle of a countdown, and the bench checks that the expiry edge does not move by even one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int          CNT_W    = 6;         // holds up to 32 half-seconds
   localparam logic [12:0] WDT_KEY  = 13'h0A57;
   localparam int          CTRL_OFF = 0;
   localparam int          MODE_OFF = 4;

   // selector -> period in half-second ticks
   function automatic logic [CNT_W-1:0] halves_of(input logic [3:0] sel);
      logic [CNT_W-1:0] s;
      s = CNT_W'(sel);
      if (sel == 4'd0)       return CNT_W'(1);
      else if (sel <= 4'd6)  return CNT_W'(s << 1);
      else if (sel <= 4'd11) return CNT_W'((s << 2) - CNT_W'(12));
      else                   return CNT_W'(32);
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int DIV = 12_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   initial assert (DIV >= 1) else $error("wdt_prescaler: DIV must be at least 1");

   generate
      if (DIV == 1) begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = clk ^ rst_n ^ clr;
         assign tick = run;
      end else begin : g_divide
         localparam int          PW   = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (clr || !run)      div_q <= '0;
            else if (div_q == LAST)    div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end

         assign tick = run && (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       stop,
   input  logic       arm_en,
   input  logic       arm_rst,
   input  logic [3:0] arm_sel,
   input  logic       tick,
   output logic       run,
   output logic       act_rst,
   output logic       expire
);
   logic [CNT_W-1:0] cnt_q, limit_q;
   logic             run_q, rst_q;
   logic             last;

   assign last   = (cnt_q == limit_q - 1'b1);
   assign expire = run_q && tick && last;
   assign run    = run_q;
   assign act_rst = rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         limit_q <= halves_of(4'd0);
         rst_q   <= 1'b0;
      end else if (stop) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (arm) begin
         run_q   <= arm_en;
         cnt_q   <= '0;
         limit_q <= halves_of(arm_sel);
         rst_q   <= arm_rst;
      end else if (run_q && tick) begin
         if (last) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < limit_q)) else $error("count passed limit"); // R4
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!run_q && cnt_q == '0)) else $error("stop did not clear"); // R8
   AST_HALT_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !arm && !stop) |=> !run_q) else $error("still running after expiry"); // R10
   AST_PENDING_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !stop) |=> ($stable(limit_q) && $stable(rst_q))) else $error("period changed without arming"); // R9
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic pulse
);
   initial assert (CYC >= 1) else $error("wdt_pulse: CYC must be at least 1");

   localparam int PW = $clog2(CYC + 1);
   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (load)           left_q <= PW'(CYC);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign pulse = (left_q != '0);

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !load && $past(pulse)) |-> (left_q < PW'(CYC))) else $error("pulse overran"); // R6
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int TICK_DIV   = 12_000_000,
   parameter int RST_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sys_rst_o,
   output logic              irq_o
);
   initial assert (ADDR_W >= 3) else $error("keyed_wdt: ADDR_W too small for mode offset");

   // stored mode word
   logic       en_q, rsten_q, flag_q;
   logic [3:0] sel_q;

   logic ctrl_hit, mode_hit, key_ok, arm, stop;
   logic arm_en, arm_rst;
   logic [3:0] arm_sel;
   logic tick, run_w, act_rst_w, expire_w;
   logic wdata_unused;

   assign wdata_unused = ^{bus_wdata[31:14], bus_wdata[2]};

   assign ctrl_hit = bus_we && (bus_addr == ADDR_W'(CTRL_OFF));
   assign mode_hit = bus_we && (bus_addr == ADDR_W'(MODE_OFF));
   assign key_ok   = ctrl_hit && bus_wdata[0] && (bus_wdata[13:1] == WDT_KEY);

   // 0->1 enable arms straight from the written word
   assign arm     = key_ok || (mode_hit && bus_wdata[0] && !en_q);
   assign stop    = mode_hit && !bus_wdata[0];
   assign arm_en  = mode_hit ? bus_wdata[0]   : en_q;
   assign arm_rst = mode_hit ? bus_wdata[1]   : rsten_q;
   assign arm_sel = mode_hit ? bus_wdata[6:3] : sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rsten_q <= 1'b0;
         sel_q   <= '0;
      end else if (mode_hit) begin
         en_q    <= bus_wdata[0];
         rsten_q <= bus_wdata[1];
         sel_q   <= bus_wdata[6:3];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q <= 1'b0;
      else if (key_ok)                 flag_q <= 1'b0;
      else if (expire_w && !act_rst_w) flag_q <= 1'b1;
   end

   wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(arm || stop), .run(run_w), .tick(tick)
   );

   wdt_countdown u_count (
      .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop),
      .arm_en(arm_en), .arm_rst(arm_rst), .arm_sel(arm_sel), .tick(tick),
      .run(run_w), .act_rst(act_rst_w), .expire(expire_w)
   );

   wdt_pulse #(.CYC(RST_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .load(expire_w && act_rst_w), .pulse(sys_rst_o)
   );

   assign irq_o = flag_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_re && bus_addr == ADDR_W'(MODE_OFF))
         bus_rdata = {25'd0, sel_q, flag_q, rsten_q, en_q};
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !key_ok) |=> irq_o) else $error("flag dropped without restart"); // R7
   AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(expire_w && act_rst_w)) else $error("reset pulse without expiry"); // R6
   AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && !key_ok && !expire_w) |=> $stable(run_w)) else $error("bad key changed countdown"); // R2
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
   localparam int D  = 4;
   localparam int RC = 3;
   localparam logic [31:0] GOOD_KEY = 32'h0000_14AF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst_o, irq_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   keyed_wdt #(.ADDR_W(8), .TICK_DIV(D), .RST_CYCLES(RC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_o(sys_rst_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected period in half-seconds, from the seconds table
   function automatic int period_halves(input int sel);
      int secs2;
      case (sel)
         0: secs2 = 1;   1: secs2 = 2;   2: secs2 = 4;   3: secs2 = 6;
         4: secs2 = 8;   5: secs2 = 10;  6: secs2 = 12;  7: secs2 = 16;
         8: secs2 = 20;  9: secs2 = 24;  10: secs2 = 28;
         default: secs2 = 32;
      endcase
      return secs2;
   endfunction

   // called right after a negedge; commits on the next posedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_re = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_re = 1'b0;
   endtask

   // n edges after the arming edge the chosen output must first be high
   task automatic expect_fire(input string req, input int n, input bit use_rst);
      repeat (n - 1) @(negedge clk);
      chk(req, use_rst ? sys_rst_o : irq_o, 0);
      @(negedge clk);
      chk(req, use_rst ? sys_rst_o : irq_o, 1);
   endtask

   task automatic clean_up;
      wr(8'h04, 32'h0);
      wr(8'h00, GOOD_KEY);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 sys_rst_o", sys_rst_o, 0);
      chk("R1 irq_o", irq_o, 0);
      rd(8'h04, d);
      chk("R1 mode read", d, 0);
   endtask

   task automatic t_layout;
      logic [31:0] d;
      wr(8'h04, 32'h0000_004A);
      rd(8'h04, d);
      chk("R3 mode readback", d, 32'h4A);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d);
      chk("R3 control reads zero", d, 0);
      rd(8'h08, d);
      chk("R3 other offset reads zero", d, 0);
      wr(8'h04, 32'h0);
   endtask

   task automatic t_table;
      int sels[5] = '{0, 2, 6, 7, 11};
      logic [31:0] d;
      foreach (sels[i]) begin
         wr(8'h04, 32'(sels[i] << 3) | 32'h1);
         expect_fire("R4 expiry time", period_halves(sels[i]) * D, 1'b0);
         rd(8'h04, d);
         chk("R7 flag in bit 2", d, 32'(sels[i] << 3) | 32'h5);
         wr(8'h00, GOOD_KEY);
         chk("R7 restart clears flag", irq_o, 0);
         wr(8'h04, 32'h0);
      end
   endtask

   task automatic t_saturate;
      for (int s = 12; s <= 15; s += 3) begin
         wr(8'h04, 32'(s << 3) | 32'h1);
         expect_fire("R5 codes above 11", 32 * D, 1'b0);
         clean_up();
      end
   endtask

   task automatic t_reset_pulse;
      bit seen = 1'b0;
      wr(8'h04, 32'h3);
      expect_fire("R6 pulse start", D, 1'b1);
      repeat (RC - 1) begin
         @(negedge clk);
         chk("R6 pulse held", sys_rst_o, 1);
      end
      @(negedge clk);
      chk("R6 pulse ends", sys_rst_o, 0);
      chk("R6 no flag", irq_o, 0);
      repeat (10 * D) begin
         @(negedge clk);
         if (sys_rst_o) seen = 1'b1;
      end
      chk("R10 halted after expiry", 32'(seen), 0);
      clean_up();
   endtask

   task automatic t_key;
      wr(8'h04, 32'h09);                  // sel 1: 8 edges
      wr(8'h00, 32'h0000_14AD);           // wrong key
      wr(8'h00, 32'h0000_14AE);           // right key, restart bit clear
      expect_fire("R2 bad key ignored", 2 * D - 2, 1'b0);
      wr(8'h00, GOOD_KEY);
      chk("R7 restart clears flag", irq_o, 0);
      repeat (3) @(negedge clk);
      wr(8'h00, GOOD_KEY);                // restart mid-run
      expect_fire("R2 keyed restart moves expiry", 2 * D, 1'b0);
      wr(8'h04, 32'h0);
      chk("R7 flag kept over disable", irq_o, 1);
      wr(8'h00, GOOD_KEY);
      chk("R7 cleared while disabled", irq_o, 0);
   endtask

   task automatic t_disable;
      wr(8'h04, 32'h09);
      repeat (4) @(negedge clk);
      wr(8'h04, 32'h08);                  // enable off
      repeat (20) @(negedge clk);
      chk("R8 stopped", irq_o, 0);
      wr(8'h04, 32'h09);
      expect_fire("R8 count cleared", 2 * D, 1'b0);
      clean_up();
   endtask

   task automatic t_pending;
      logic [31:0] d;
      wr(8'h04, 32'h11);                  // sel 2: 16 edges
      wr(8'h04, 32'h01);                  // sel 0 pending
      expect_fire("R9 pending change not applied", 4 * D - 1, 1'b0);
      rd(8'h04, d);
      chk("R9 stored word", d, 32'h05);
      wr(8'h00, GOOD_KEY);
      chk("R9 restart clears flag", irq_o, 0);
      expect_fire("R9 applied at restart", D, 1'b0);
      clean_up();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_table();
      t_saturate();
      t_reset_pulse();
      t_key();
      t_disable();
      t_pending();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule